// File: doc/BRIEF.md
# GPIO Port Register Block

A register-mapped controller for a bank of up to 32 general-purpose pins. A word-wide register bus (address, write enable, write data, combinational read data) programs each pin's function code. It also drives the pin output register through separate set and clear strobes, returns the pin levels, and loads pull resistor modes into chosen pins.

Output values change only through two write-only strobe registers. Writing ones to the set register raises those pins and writing ones to the clear register lowers them, so software never needs a read-modify-write to touch one pin. Pull resistor control takes two steps. A single shared mode register holds off, pull-down or pull-up. A pull clock mask then selects which pins take that mode. Each pin keeps its latched mode after its clock bit is removed.

The block exports, per pin, the output value, an output enable, the raw 3-bit function code, an alternate-function flag and a 2-bit pull code. These go to the pad ring and to the peripheral muxes.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every function code is 000 (input), the output register is zero, all output enables, alternate flags and pull codes are zero, and the pull mode and pull clock registers read zero.
- R2: Function codes are 3 bits per pin, ten pins per word. Pin p sits in word p/10 (word addresses 0 to 3) at bits 3*(p%10)+2 down to 3*(p%10). Bits 31:30 of each word, and any field without a pin, read as zero.
- R3: Code 000 is input and 001 is output. Codes 100, 101, 110, 111, 011 and 010 are alternate functions 0 to 5. fsel_o exports each pin's code, and alt_en_o is high exactly for the six alternate codes.
- R4: oe_o of a pin is high only when its code is 001. out_o of a pin equals its output register bit when oe_o is high and is 0 otherwise.
- R5: A write to address 4 sets the output register bit of every pin whose write data bit is 1, effective on the clock edge of the write. Bits written as 0 keep their value.
- R6: A write to address 5 clears the output register bit of every pin whose write data bit is 1, effective on the clock edge of the write. Bits written as 0 keep their value.
- R7: Addresses 4 and 5 always read as zero.
- R8: The output register keeps its value while a pin is in input or alternate mode. A value set or cleared in those modes appears on out_o once the pin's code becomes 001.
- R9: Address 6 reads the pin levels pin_i through a SYNC_STAGES-flop synchronizer (two by default), whatever the function codes are.
- R10: Address 7 holds the shared pull mode in bits 1:0: 00 off, 01 pull-down, 10 pull-up. Writing 11 stores 00. Pull codes on pull_o never take the value 11.
- R11: Address 8 holds the pull clock mask. On each clock edge where a pin's mask bit is 1, that pin's pull code loads the shared mode. pull_o therefore follows a mode or mask write one cycle after that write's edge, and keeps tracking while the bit stays set.
- R12: A pin whose pull clock bit is 0 keeps its latched pull code, including after the bit is cleared and the shared mode then changes.
- R13: Writes to the set and clear registers on consecutive cycles for the same pin leave the value of the later write.
- R14: Addresses 9 to 15 read as zero. Writes to them or to address 6 change no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | NPINS | Pad input levels |
| out_o | output | NPINS | Pin output values |
| oe_o | output | NPINS | Per-pin output enable |
| alt_en_o | output | NPINS | Per-pin alternate-function flag |
| fsel_o | output | 3*NPINS | Per-pin function code, pin p at bits 3p+2:3p |
| pull_o | output | 2*NPINS | Per-pin pull code, pin p at bits 2p+1:2p |

## Verification
The assertions check several rules on every cycle. A set or clear write lands on the addressed bits. The output register stays still when neither strobe is written. No pin is both enabled and in an alternate mode, and no pin drives while disabled. The strobe registers read zero, and the reserved pull code never appears. A pin whose clock bit was low cannot change its pull code. The bench scenarios cover the rest: the field layout and code decoding, retention of the output value across mode changes, the synchronizer latency on the level register, the last-write-wins ordering of back-to-back strobes, and the silence of unmapped addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned FS_W        = 3;
  localparam int unsigned FS_PER_WORD = 10;
  localparam int unsigned PULL_W      = 2;

  localparam logic [ADDR_W-1:0] ADR_FSEL0 = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_SET   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_LEVEL = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_PMODE = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_PCLK  = 4'd8;

  typedef enum logic [FS_W-1:0] {
    FS_IN   = 3'b000,
    FS_OUT  = 3'b001,
    FS_ALT0 = 3'b100,
    FS_ALT1 = 3'b101,
    FS_ALT2 = 3'b110,
    FS_ALT3 = 3'b111,
    FS_ALT4 = 3'b011,
    FS_ALT5 = 3'b010
  } fsel_e;

  typedef enum logic [PULL_W-1:0] {
    PULL_OFF  = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10
  } pull_e;

  // reserved code 11 collapses to off
  function automatic logic [PULL_W-1:0] legal_pull(logic [PULL_W-1:0] m);
    return (m == 2'b11) ? PULL_OFF : m;
  endfunction
endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned NWORDS = (NPINS + FS_PER_WORD - 1) / FS_PER_WORD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [NPINS*FS_W-1:0]    fsel_o,
  output logic [NPINS-1:0]         oe_o,
  output logic [NPINS-1:0]         alt_o,
  output logic [NWORDS*DATA_W-1:0] words_o
);
  logic [NPINS-1:0][FS_W-1:0] fsel_q;
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:FS_PER_WORD*FS_W];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int unsigned WRD = p / FS_PER_WORD;
    localparam int unsigned FLD = p % FS_PER_WORD;
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_FSEL0 + ADDR_W'(WRD);
    logic [FS_W-1:0] code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           code_q <= FS_IN;
      else if (wr_i && (addr_i == MY_ADR))  code_q <= wdata_i[FLD*FS_W +: FS_W];
    end

    assign fsel_q[p] = code_q;
    assign oe_o[p]   = (code_q == FS_OUT);
    assign alt_o[p]  = |code_q[FS_W-1:1];  // 1xx, 011, 010
  end

  assign fsel_o = fsel_q;

  always_comb begin
    words_o = '0;
    for (int p = 0; p < NPINS; p++)
      words_o[(p / FS_PER_WORD)*DATA_W + (p % FS_PER_WORD)*FS_W +: FS_W] = fsel_q[p];
  end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [NPINS-1:0] bits_i,
  output logic [NPINS-1:0] out_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q_o <= '0;
    else if (set_i)  out_q_o <= out_q_o | bits_i;
    else if (clr_i)  out_q_o <= out_q_o & ~bits_i;
  end
endmodule

// File: rtl/gpio_pull_ctl.sv
module gpio_pull_ctl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_wr_i,
  input  logic                    mask_wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [PULL_W-1:0]       mode_o,
  output logic [NPINS-1:0]        mask_o,
  output logic [NPINS*PULL_W-1:0] pull_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= PULL_OFF;
      mask_o <= '0;
    end else begin
      if (mode_wr_i) mode_o <= legal_pull(wdata_i[PULL_W-1:0]);
      if (mask_wr_i) mask_o <= wdata_i[NPINS-1:0];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [PULL_W-1:0] pin_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pin_q <= PULL_OFF;
      else if (mask_o[p]) pin_q <= mode_o;
    end
    assign pull_o[p*PULL_W +: PULL_W] = pin_q;
  end
endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] level_o
);
  logic [STAGES-1:0][NPINS-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [NPINS-1:0]        pin_i,
  output logic [NPINS-1:0]        out_o,
  output logic [NPINS-1:0]        oe_o,
  output logic [NPINS-1:0]        alt_en_o,
  output logic [NPINS*FS_W-1:0]   fsel_o,
  output logic [NPINS*PULL_W-1:0] pull_o
);
  localparam int unsigned NWORDS = (NPINS + FS_PER_WORD - 1) / FS_PER_WORD;

  logic [NWORDS*DATA_W-1:0] fs_words;
  logic [NPINS-1:0]         out_q;
  logic [NPINS-1:0]         level;
  logic [PULL_W-1:0]        pmode_q;
  logic [NPINS-1:0]         pmask_q;

  gpio_fsel_bank #(.NPINS(NPINS)) u_fsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .fsel_o  (fsel_o),
    .oe_o    (oe_o),
    .alt_o   (alt_en_o),
    .words_o (fs_words)
  );

  gpio_out_reg #(.NPINS(NPINS)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (we_i && (addr_i == ADR_SET)),
    .clr_i   (we_i && (addr_i == ADR_CLR)),
    .bits_i  (wdata_i[NPINS-1:0]),
    .out_q_o (out_q)
  );

  gpio_pull_ctl #(.NPINS(NPINS)) u_pull (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_wr_i (we_i && (addr_i == ADR_PMODE)),
    .mask_wr_i (we_i && (addr_i == ADR_PCLK)),
    .wdata_i   (wdata_i),
    .mode_o    (pmode_q),
    .mask_o    (pmask_q),
    .pull_o    (pull_o)
  );

  gpio_level_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_o (level)
  );

  // alternate and input modes hide the output register
  assign out_o = out_q & oe_o;

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWORDS; w++)
      if (addr_i == ADR_FSEL0 + ADDR_W'(w)) rdata_o = fs_words[w*DATA_W +: DATA_W];
    case (addr_i)
      ADR_LEVEL: rdata_o[NPINS-1:0]  = level;
      ADR_PMODE: rdata_o[PULL_W-1:0] = pmode_q;
      ADR_PCLK:  rdata_o[NPINS-1:0]  = pmask_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    we_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic [NPINS-1:0]        out_o,
  input logic [NPINS-1:0]        oe_o,
  input logic [NPINS-1:0]        alt_en_o,
  input logic [NPINS*PULL_W-1:0] pull_o,
  input logic [NPINS-1:0]        out_q,
  input logic [PULL_W-1:0]       pmode_q,
  input logic [NPINS-1:0]        pmask_q
);
  logic [NPINS*PULL_W-1:0] mask_x;
  always_comb
    for (int p = 0; p < NPINS; p++) mask_x[p*PULL_W +: PULL_W] = {PULL_W{pmask_q[p]}};

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_SET) |=> ((out_q & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0]))); // R5
  AST_CLR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_CLR) |=> ((out_q & $past(wdata_i[NPINS-1:0])) == '0)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == ADR_SET || addr_i == ADR_CLR)) |=> $stable(out_q)); // R8
  AST_STROBE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_SET || addr_i == ADR_CLR) |-> (rdata_o == '0)); // R7
  AST_NO_DRIVE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_o & ~oe_o) == '0)); // R4
  AST_OE_ALT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((oe_o & alt_en_o) == '0)); // R3
  AST_PULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pull_o ^ $past(pull_o)) & ~$past(mask_x)) == '0)); // R12
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_q != 2'b11)); // R10
  AST_UNMAPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > ADR_PCLK) |=> ($stable(out_q) && $stable(pmode_q) && $stable(pmask_q))); // R14

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    AST_PULL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pull_o[p*PULL_W +: PULL_W] != 2'b11)); // R10
  end
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .out_o    (out_o),
  .oe_o     (oe_o),
  .alt_en_o (alt_en_o),
  .pull_o   (pull_o),
  .out_q    (out_q),
  .pmode_q  (pmode_q),
  .pmask_q  (pmask_q)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam logic [3:0] AD_SET = 4'd4, AD_CLR = 4'd5, AD_LVL = 4'd6,
                         AD_PMODE = 4'd7, AD_PCLK = 4'd8, AD_IDLE = 4'd15;

  typedef enum {SRC_RD, SRC_OUT, SRC_OE, SRC_ALT, SRC_FSEL, SRC_PULL} src_e;
  typedef struct {src_e src; logic [127:0] exp; int due; string req;} item_t;

  logic clk = 0, rst_n = 0, we = 0;
  logic [3:0] addr = AD_IDLE;
  logic [31:0] wdata = '0, rdata, pin = '0;
  logic [NP-1:0] out_w, oe_w, alt_w;
  logic [NP*3-1:0] fsel_w;
  logic [NP*2-1:0] pull_w;

  gpio_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .out_o(out_w), .oe_o(oe_w), .alt_en_o(alt_w),
    .fsel_o(fsel_w), .pull_o(pull_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, n_vec = 0, n_bad = 0;
  bit done = 0;
  item_t sb[$];
  always @(posedge clk) cyc <= cyc + 1;

  // bench model
  logic [2:0]  m_fs[NP];
  logic [1:0]  m_pull[NP];
  logic [31:0] m_outq;

  function automatic logic [127:0] actual(src_e s);
    case (s)
      SRC_RD:   return 128'(rdata);
      SRC_OUT:  return 128'(out_w);
      SRC_OE:   return 128'(oe_w);
      SRC_ALT:  return 128'(alt_w);
      SRC_FSEL: return 128'(fsel_w);
      default:  return 128'(pull_w);
    endcase
  endfunction

  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      n_vec++;
      if (actual(it.src) !== it.exp) begin
        n_bad++;
        $display("FAIL %s src=%s actual=%0h expected=%0h", it.req, it.src.name(), actual(it.src), it.exp);
      end
    end
  end

  function automatic logic [31:0] fs_word(int w);
    logic [31:0] v = '0;
    for (int f = 0; f < 10; f++) if (w*10 + f < NP) v[f*3 +: 3] = m_fs[w*10 + f];
    return v;
  endfunction
  function automatic logic [31:0] m_oe();
    logic [31:0] v = '0;
    for (int p = 0; p < NP; p++) v[p] = (m_fs[p] == 3'b001);
    return v;
  endfunction
  function automatic logic [31:0] m_alt();
    logic [31:0] v = '0;
    for (int p = 0; p < NP; p++) v[p] = m_fs[p][2] | m_fs[p][1];
    return v;
  endfunction
  function automatic logic [127:0] m_fsflat();
    logic [127:0] v = '0;
    for (int p = 0; p < NP; p++) v[p*3 +: 3] = m_fs[p];
    return v;
  endfunction
  function automatic logic [127:0] m_pullflat();
    logic [127:0] v = '0;
    for (int p = 0; p < NP; p++) v[p*2 +: 2] = m_pull[p];
    return v;
  endfunction

  task automatic push(src_e s, logic [127:0] e, int lag, string r);
    item_t it;
    it.src = s; it.exp = e; it.due = cyc + lag; it.req = r;
    sb.push_back(it);
  endtask
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; we = 1; wdata = d;
    @(posedge clk); #1;
    we = 0; addr = AD_IDLE; wdata = '0;
  endtask
  task automatic wr2(logic [3:0] a1, logic [31:0] d1, logic [3:0] a2, logic [31:0] d2);
    @(posedge clk); #1;
    addr = a1; we = 1; wdata = d1;
    @(posedge clk); #1;
    addr = a2; wdata = d2;
    @(posedge clk); #1;
    we = 0; addr = AD_IDLE; wdata = '0;
  endtask
  task automatic rd_chk(logic [3:0] a, logic [31:0] e, string r);
    @(posedge clk); #1;
    addr = a;
    push(SRC_RD, 128'(e), 0, r);
    @(negedge clk); #1;
    addr = AD_IDLE;
  endtask
  task automatic chk_pins(string r);
    push(SRC_OUT, 128'(m_outq & m_oe()), 0, r);
    push(SRC_OE, 128'(m_oe()), 0, r);
    push(SRC_ALT, 128'(m_alt()), 0, r);
    push(SRC_FSEL, m_fsflat(), 0, r);
  endtask
  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog (R1..) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_fs[p] = 3'b000; m_pull[p] = 2'b00; end
    m_outq = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_pins("R1");
    push(SRC_PULL, m_pullflat(), 0, "R1");
    for (int w = 0; w < 4; w++) rd_chk(4'(w), 32'h0, "R1");
    rd_chk(AD_PMODE, 32'h0, "R1");
    rd_chk(AD_PCLK, 32'h0, "R1");

    // R2/R3 layout and encoding: word 0 gets in,out,alt0..alt5,out,in
    m_fs[0] = 3'b000; m_fs[1] = 3'b001; m_fs[2] = 3'b100; m_fs[3] = 3'b101;
    m_fs[4] = 3'b110; m_fs[5] = 3'b111; m_fs[6] = 3'b011; m_fs[7] = 3'b010;
    m_fs[8] = 3'b001; m_fs[9] = 3'b000;
    wr(4'd0, fs_word(0) | 32'hC000_0000);
    chk_pins("R3");
    rd_chk(4'd0, fs_word(0), "R2");
    m_fs[30] = 3'b001; m_fs[31] = 3'b111;
    wr(4'd3, fs_word(3) | 32'hFFFF_FFC0);
    chk_pins("R2");
    rd_chk(4'd3, fs_word(3), "R2");
    m_fs[15] = 3'b101;
    wr(4'd1, fs_word(1));
    chk_pins("R2");
    rd_chk(4'd1, fs_word(1), "R2");

    // R5 set, zeros ignored; pin 31 alternate so gated (R4)
    m_outq = 32'hC000_0102;
    wr(AD_SET, 32'hC000_0102);
    chk_pins("R5");
    wr(AD_SET, 32'h0000_0002);
    chk_pins("R5");

    // R6 clear
    m_outq &= ~32'h0000_0100;
    wr(AD_CLR, 32'h0000_0100);
    chk_pins("R6");

    // R7 strobes read zero
    rd_chk(AD_SET, 32'h0, "R7");
    rd_chk(AD_CLR, 32'h0, "R7");

    // R8 value set during alternate mode appears on switch to output
    m_fs[31] = 3'b001;
    wr(4'd3, fs_word(3));
    chk_pins("R8");
    push(SRC_OUT, 128'(32'hC000_0002), 0, "R8");

    // R4 alternate hides output; return restores it
    m_fs[1] = 3'b100;
    wr(4'd0, fs_word(0));
    chk_pins("R4");
    m_outq &= ~32'h4000_0000;
    wr(AD_CLR, 32'h4000_0000);
    m_fs[1] = 3'b001;
    wr(4'd0, fs_word(0));
    chk_pins("R8");

    // R13 back-to-back strobes on pin 8
    m_outq &= ~32'h100;
    wr2(AD_SET, 32'h100, AD_CLR, 32'h100);
    chk_pins("R13");
    m_outq |= 32'h100;
    wr2(AD_CLR, 32'h100, AD_SET, 32'h100);
    chk_pins("R13");

    // R9 level latency and mode independence
    @(posedge clk); #1 pin = 32'hA5A5_0F0F;
    rd_chk(AD_LVL, 32'h0, "R9");
    rd_chk(AD_LVL, 32'hA5A5_0F0F, "R9");
    @(posedge clk); #1 pin = 32'h0000_0102;
    rd_chk(AD_LVL, 32'hA5A5_0F0F, "R9");
    rd_chk(AD_LVL, 32'h0000_0102, "R9");

    // R10 pull mode encoding
    wr(AD_PMODE, 32'hFFFF_FFFF);
    rd_chk(AD_PMODE, 32'h0, "R10");
    wr(AD_PMODE, 32'h2);
    rd_chk(AD_PMODE, 32'h2, "R10");
    push(SRC_PULL, m_pullflat(), 0, "R11");

    // R11 apply via clock mask, then track
    m_pull[0] = 2'b10; m_pull[4] = 2'b10;
    wr(AD_PCLK, 32'h11);
    push(SRC_PULL, m_pullflat(), 1, "R11");
    rd_chk(AD_PCLK, 32'h11, "R11");
    m_pull[0] = 2'b01; m_pull[4] = 2'b01;
    wr(AD_PMODE, 32'h1);
    push(SRC_PULL, m_pullflat(), 1, "R11");
    drain();

    // R12 released pin keeps its code
    wr(AD_PCLK, 32'h1);
    m_pull[0] = 2'b10;
    wr(AD_PMODE, 32'h2);
    push(SRC_PULL, m_pullflat(), 1, "R12");
    wr(AD_PCLK, 32'h0);
    wr(AD_PMODE, 32'h0);
    push(SRC_PULL, m_pullflat(), 1, "R12");
    drain();

    // R14 unmapped and read-only addresses
    rd_chk(4'd9, 32'h0, "R14");
    rd_chk(4'd15, 32'h0, "R14");
    wr(4'd12, 32'hFFFF_FFFF);
    wr(AD_LVL, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    chk_pins("R14");
    push(SRC_PULL, m_pullflat(), 1, "R14");
    for (int w = 0; w < 4; w++) rd_chk(4'(w), fs_word(w), "R14");
    rd_chk(AD_PMODE, 32'h0, "R14");
    rd_chk(AD_PCLK, 32'h0, "R14");
    rd_chk(AD_LVL, 32'h0000_0102, "R14");

    drain();
    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule